// File: doc/BRIEF.md
# Two-Level Predecoded 6-to-64 Address Decoder

This block turns a 6-bit binary address into a 64-bit one-hot select vector. It has no clock and no state. Instead of giving every output its own six-input product term, it first splits the address into three 2-bit fields. Each field drives a small 2-to-4 predecoder, and each output line is then a three-input AND that takes one line from each predecoder.

The three predecoder vectors are also brought out as ports. An integrator can observe them during bring-up, and a bench can check the middle stage directly. The usual setting is row or word-line selection in front of a 64-entry array, where the shared predecode cuts gate inputs and fan-in on the slow path.

Top module: `predec_addr_decoder`

## Requirements
- R1: `pre_lo_o` is the one-hot image of `addr_i[1:0]`, `pre_mid_o` is the one-hot image of `addr_i[3:2]`, and `pre_hi_o` is the one-hot image of `addr_i[5:4]`. Line k of a predecoder is bit k of its port.
- R2: Each of the three predecoder ports has exactly one bit high for every known address.
- R3: Output bit i equals `pre_lo_o[i[1:0]] & pre_mid_o[i[3:2]] & pre_hi_o[i[5:4]]`.
- R4: Output bit number `addr_i` is high.
- R5: Exactly one bit of `onehot_o` is high for every known address.
- R6: The block is purely combinational. The outputs follow a change on `addr_i` in the same time step, with no clock edge involved.
- R7: For every one of the 64 address codes, `onehot_o` equals 64'd1 shifted left by `addr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 6 | Binary address to decode |
| onehot_o | output | 64 | One-hot select; bit `addr_i` is set |
| pre_lo_o | output | 4 | Predecode of address bits 1:0 |
| pre_mid_o | output | 4 | Predecode of address bits 3:2 |
| pre_hi_o | output | 4 | Predecode of address bits 5:4 |

## Verification
The embedded assertions check these properties whenever the address is known:
- each predecoder is one-hot and points at its own field;
- the output is one-hot with the addressed bit set;
- the output matches a flat shift-based decode.

Only the bench scenarios show the remaining behaviour:
- every one of the 64 codes is reached;
- the outputs settle without any clock edge;
- the AND-of-three structure holds bit by bit against a model built independently of the design.

// File: rtl/predec_addr_decoder.sv
module predec_addr_decoder #(
  parameter int FLD_W = 2
) (
  input  logic [3*FLD_W-1:0]        addr_i,
  output logic [(1<<(3*FLD_W))-1:0] onehot_o,
  output logic [(1<<FLD_W)-1:0]     pre_lo_o,
  output logic [(1<<FLD_W)-1:0]     pre_mid_o,
  output logic [(1<<FLD_W)-1:0]     pre_hi_o
);
  localparam int ADDR_W = 3 * FLD_W;
  localparam int LINES  = 1 << FLD_W;
  localparam int OUT_W  = 1 << ADDR_W;

  logic [FLD_W-1:0] fld_lo, fld_mid, fld_hi;
  assign fld_lo  = addr_i[FLD_W-1:0];
  assign fld_mid = addr_i[2*FLD_W-1:FLD_W];
  assign fld_hi  = addr_i[3*FLD_W-1:2*FLD_W];

  // first level: three small predecoders, one per address field
  for (genvar k = 0; k < LINES; k++) begin : g_pre
    assign pre_lo_o[k]  = (fld_lo  == FLD_W'(k));
    assign pre_mid_o[k] = (fld_mid == FLD_W'(k));
    assign pre_hi_o[k]  = (fld_hi  == FLD_W'(k));
  end

  // second level: each output is a three-input AND across the predecoders
  for (genvar i = 0; i < OUT_W; i++) begin : g_out
    localparam int L = i % LINES;
    localparam int M = (i / LINES) % LINES;
    localparam int H = i / (LINES * LINES);
    assign onehot_o[i] = pre_lo_o[L] & pre_mid_o[M] & pre_hi_o[H];
  end

  always_comb begin
    if (!$isunknown(addr_i)) begin
      AST_PRE_LO_ONEHOT: assert ($countones(pre_lo_o) == 1) else $error("pre_lo not one-hot"); // R2
      AST_PRE_MID_ONEHOT: assert ($countones(pre_mid_o) == 1) else $error("pre_mid not one-hot"); // R2
      AST_PRE_HI_ONEHOT: assert ($countones(pre_hi_o) == 1) else $error("pre_hi not one-hot"); // R2
      AST_PRE_FIELD_MAP: assert (pre_lo_o[addr_i[1:0]] && pre_mid_o[addr_i[3:2]] && pre_hi_o[addr_i[5:4]]) else $error("predecode field mismatch"); // R1
      AST_OUT_ONEHOT: assert ($countones(onehot_o) == 1) else $error("output not one-hot"); // R5
      AST_OUT_ADDRESSED: assert (onehot_o[addr_i]) else $error("addressed bit low"); // R4
      AST_FLAT_EQUIV: assert (onehot_o == (OUT_W'(1) << addr_i)) else $error("flat decode mismatch"); // R7
    end
  end
endmodule

// File: tb/predec_addr_decoder_test.sv
module predec_addr_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  addr;
  logic [63:0] y;
  logic [3:0]  plo, pmid, phi;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  predec_addr_decoder uut (
    .addr_i(addr), .onehot_o(y),
    .pre_lo_o(plo), .pre_mid_o(pmid), .pre_hi_o(phi)
  );

  localparam logic [5:0] TV_A [8] = '{6'd0, 6'd1, 6'd2, 6'd21, 6'd42, 6'd32, 6'd62, 6'd63};
  localparam logic [63:0] TV_Y [8] = '{
    64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002,
    64'h0000_0000_0000_0004, 64'h0000_0000_0020_0000,
    64'h0000_0400_0000_0000, 64'h0000_0001_0000_0000,
    64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] oh4(input logic [1:0] f);
    return 4'b0001 << f;
  endfunction

  initial begin
    addr = 6'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R4 reset state addr0", y, 64'h1);

    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      addr = TV_A[t];
      #1;
      chk("R7 table vector", y, TV_Y[t]);
    end

    for (int a = 0; a < 64; a++) begin
      logic [5:0] av;
      logic [63:0] prod;
      @(negedge clk);
      av = 6'(a);
      addr = av;
      #1;
      chk("R7 flat shift", y, 64'd1 << av);
      chk("R1 low field", {60'd0, plo}, {60'd0, oh4(av[1:0])});
      chk("R1 mid field", {60'd0, pmid}, {60'd0, oh4(av[3:2])});
      chk("R1 high field", {60'd0, phi}, {60'd0, oh4(av[5:4])});
      chk("R2 predecoders one-hot",
          64'(($countones(plo) == 1) && ($countones(pmid) == 1) && ($countones(phi) == 1)), 64'd1);
      chk("R5 one output high", 64'($countones(y)), 64'd1);
      chk("R4 addressed bit", 64'(y[av]), 64'd1);
      prod = '0;
      for (int i = 0; i < 64; i++) begin
        logic [5:0] iv;
        iv = 6'(i);
        prod[i] = plo[iv[1:0]] & pmid[iv[3:2]] & phi[iv[5:4]];
      end
      chk("R3 AND of three lines", y, prod);
    end

    @(posedge clk);
    #1 addr = 6'd63;
    #0.5;
    chk("R6 settles without edge, code 63", y, 64'h8000_0000_0000_0000);
    addr = 6'd0;
    #0.5;
    chk("R6 settles without edge, code 0", y, 64'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule